// File: doc/BRIEF.md
# PCM Telemetry Minor-Frame Synchronizer

This block sits behind a bit synchronizer. It receives a recovered serial PCM stream, one bit per cycle in which the bit-clock enable is high, and finds where each minor frame starts. A sliding correlator compares the most recent bits with a programmable sync pattern. The pattern can be up to 64 bits long, and a candidate counts as a match while the number of disagreeing bits stays within a programmable tolerance. A three-state machine decides when the data can be trusted. The states are SEARCH (hunting on every bit), CHECK (confirming at the predicted position) and LOCK (trusted, with a flywheel across damaged sync words). Entry to lock and exit from it each use their own programmable count.

The block produces a lock flag and several timing pulses. The minor-frame pulse and the sync-found pulse are each stretched over a programmable number of bit times. The word pulse lasts one bit time and marks the end of every data word. A four-way selectable pulse output carries any one of these three pulses or an external one-pulse-per-second input. The transitions are named as follows. FOUND takes the block from SEARCH to CHECK. FOUND_LOCK takes it from SEARCH straight to LOCK when the lock count is 1. CONFIRM takes it from CHECK to LOCK. REJECT takes it from CHECK back to SEARCH. DROP takes it from LOCK back to SEARCH.

Top module: `pcm_frame_sync`

## Requirements
- R1: The correlator uses the lowest `cfg_sync_len` bits of `cfg_sync_pattern`. Pattern bit i is compared with the bit received i bit times before the current one, so bit 0 is compared with the newest bit and bit `cfg_sync_len`-1 with the oldest. The comparison matches when the count of differing bits is at or below `cfg_tolerance` (0 to 63).
- R2: In SEARCH every received bit is a candidate end of sync. In CHECK and LOCK the only candidate is the bit exactly F = `cfg_frame_words` x `cfg_word_len` bit times after the previously accepted sync end. A sync pattern arriving anywhere else is ignored.
- R3: `locked` rises on the bit that completes `cfg_lock_count` (1 to 16) consecutive matches, counting the match that left SEARCH. A failed check in CHECK returns the block to SEARCH and clears the count.
- R4: While the block is in LOCK, `cfg_loss_count` (1 to 16) consecutive failed checks clear `locked`, on the bit of the last one. Any good check resets the miss count. Frame timing keeps running across the misses.
- R5: While the block is in LOCK, or on the bit that enters it, each predicted frame-end bit raises `frame_pulse` for `cfg_stretch` (4 to 16) bit times, starting with that bit.
- R6: Every accepted match raises `sync_found` for `cfg_stretch` bit times, starting with the matching bit. An accepted match is any match in SEARCH, or a match at the predicted position in CHECK or LOCK.
- R7: `word_pulse` is high for exactly one bit time on the last bit of each `cfg_word_len`-bit word while the block is locked. Word ends fall every `cfg_word_len` bits counted from the sync end.
- R8: `sel_pulse` carries the pulse chosen by `cfg_pulse_sel`: 0 selects frame_pulse, 1 sync_found, 2 word_pulse and 3 pps_in.
- R9: In cycles where `bit_en` is low, no output or internal state changes. All counts and stretch lengths are measured in bit times.
- R10: After reset the block is in SEARCH and `locked`, `sync_found`, `frame_pulse` and `word_pulse` are all low.
- R11: Pattern bits at or above `cfg_sync_len` have no effect on matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | High in cycles that carry a new PCM bit |
| bit_in | input | 1 | Recovered PCM data bit |
| pps_in | input | 1 | External one-pulse-per-second input |
| cfg_sync_pattern | input | 64 | Sync pattern; bit 0 is compared with the last-received bit |
| cfg_sync_len | input | 7 | Sync length in bits, 1 to 64 |
| cfg_tolerance | input | 6 | Allowed bit errors in a match |
| cfg_word_len | input | 5 | Bits per word, 4 to 16 |
| cfg_frame_words | input | 10 | Words per minor frame, sync included |
| cfg_lock_count | input | 5 | Matches needed to lock, 1 to 16 |
| cfg_loss_count | input | 5 | Misses needed to drop lock, 1 to 16 |
| cfg_stretch | input | 5 | Pulse stretch in bit times, 4 to 16 |
| cfg_pulse_sel | input | 2 | Selects the signal on sel_pulse |
| locked | output | 1 | Frame data valid |
| sync_found | output | 1 | Stretched sync-match pulse |
| frame_pulse | output | 1 | Stretched minor-frame pulse |
| word_pulse | output | 1 | One-bit-time end-of-word pulse |
| sel_pulse | output | 1 | Selected pulse |

## Verification
The stream is made of pseudo-random data with sync words placed one frame apart. Some sync words are exact copies, some carry flipped bits just inside the tolerance and some carry flipped bits just outside it. Comparing these variants separates the handling of the tolerance edge from plain equality. One sync is placed off its predicted slot while the block is locked: this shows whether the correlator really gates on position or still reacts to any match. Runs with and without gaps in the bit enable show whether stretch widths and counts are taken in bit times rather than clock cycles. A second configuration uses a different word length, a lock count of 1 and a loss count of 1, together with a sync pattern whose upper unused bits are set. It exercises the direct SEARCH-to-LOCK path, the single-miss DROP and the masking of bits above the sync length.

// File: rtl/pcm_fs_pkg.sv
package pcm_fs_pkg;
    typedef enum logic [1:0] {
        FS_SEARCH = 2'd0,
        FS_CHECK  = 2'd1,
        FS_LOCK   = 2'd2
    } fs_state_e;

    typedef enum logic [1:0] {
        SEL_FRAME = 2'd0,
        SEL_SYNC  = 2'd1,
        SEL_WORD  = 2'd2,
        SEL_PPS   = 2'd3
    } pulse_sel_e;
endpackage

// File: rtl/pcm_fs_corr.sv
// Sliding-window sync correlator with error tolerance.
module pcm_fs_corr #(
    parameter int SYNC_MAX = 64,
    parameter int TOL_W    = 6,
    localparam int LEN_W   = $clog2(SYNC_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                bit_in,
    input  logic [SYNC_MAX-1:0] pattern,
    input  logic [LEN_W-1:0]    sync_len,
    input  logic [TOL_W-1:0]    tol,
    output logic                match
);
    localparam int ERR_W = $clog2(SYNC_MAX + 1);

    logic [SYNC_MAX-1:0] hist_q;
    logic [SYNC_MAX-1:0] window;
    logic [SYNC_MAX-1:0] len_mask;
    logic [SYNC_MAX-1:0] diff;
    logic [ERR_W-1:0]    err_cnt;

    assign window = {hist_q[SYNC_MAX-2:0], bit_in};

    // Mask of the bit positions that belong to the programmed sync length
    for (genvar i = 0; i < SYNC_MAX; i++) begin : g_mask
        assign len_mask[i] = (LEN_W'(i) < sync_len);
    end

    assign diff = (window ^ pattern) & len_mask;

    always_comb begin
        err_cnt = '0;
        for (int i = 0; i < SYNC_MAX; i++) begin
            err_cnt = err_cnt + ERR_W'(diff[i]);
        end
    end

    assign match = bit_en && (int'(err_cnt) <= int'(tol));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (bit_en) begin
            hist_q <= window;
        end
    end
endmodule

// File: rtl/pcm_fs_timing.sv
// Frame-position and word-position counters, realigned on accepted sync.
module pcm_fs_timing #(
    parameter int WLEN_W = 5,
    parameter int POS_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              realign,
    input  logic [POS_W-1:0]  frame_len,
    input  logic [WLEN_W-1:0] word_len,
    output logic              at_exp,
    output logic              word_end
);
    logic [POS_W-1:0]  pos_q, pos_inc, pos_last;
    logic [WLEN_W-1:0] wb_q, wb_inc, wb_last;

    assign pos_last = frame_len - POS_W'(1);
    assign wb_last  = word_len - WLEN_W'(1);

    assign pos_inc = (pos_q >= pos_last) ? '0 : pos_q + POS_W'(1);
    assign wb_inc  = (wb_q >= wb_last) ? '0 : wb_q + WLEN_W'(1);

    // The bit now arriving closes a predicted frame
    assign at_exp   = (pos_inc == pos_last);
    assign word_end = realign || (wb_inc == wb_last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            wb_q  <= '0;
        end else if (bit_en) begin
            pos_q <= realign ? pos_last : pos_inc;
            wb_q  <= realign ? wb_last : wb_inc;
        end
    end
endmodule

// File: rtl/pcm_fs_stretch.sv
// Retriggerable pulse stretcher counted in bit times.
module pcm_fs_stretch #(
    parameter int STR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             trig,
    input  logic [STR_W-1:0] len,
    output logic             pulse
);
    logic [STR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (bit_en) begin
            if (trig) begin
                cnt_q <= len;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - STR_W'(1);
            end
        end
    end

    assign pulse = (cnt_q != '0);
endmodule

// File: rtl/pcm_frame_sync.sv
// Minor-frame synchronizer: search / check / lock with hysteresis.
module pcm_frame_sync
    import pcm_fs_pkg::*;
#(
    parameter int SYNC_MAX = 64,
    parameter int TOL_W    = 6,
    parameter int HYST_W   = 5,
    parameter int WLEN_W   = 5,
    parameter int WPF_W    = 10,
    parameter int STR_W    = 5,
    localparam int LEN_W   = $clog2(SYNC_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                bit_in,
    input  logic                pps_in,
    input  logic [SYNC_MAX-1:0] cfg_sync_pattern,
    input  logic [LEN_W-1:0]    cfg_sync_len,
    input  logic [TOL_W-1:0]    cfg_tolerance,
    input  logic [WLEN_W-1:0]   cfg_word_len,
    input  logic [WPF_W-1:0]    cfg_frame_words,
    input  logic [HYST_W-1:0]   cfg_lock_count,
    input  logic [HYST_W-1:0]   cfg_loss_count,
    input  logic [STR_W-1:0]    cfg_stretch,
    input  logic [1:0]          cfg_pulse_sel,
    output logic                locked,
    output logic                sync_found,
    output logic                frame_pulse,
    output logic                word_pulse,
    output logic                sel_pulse
);
    localparam int POS_W  = WPF_W + WLEN_W;
    localparam int HW1    = HYST_W + 1;
    localparam int N_STR  = 2;
    localparam int IX_FRM = 0;
    localparam int IX_SYN = 1;

    fs_state_e         state_q, state_d;
    logic [HYST_W-1:0] mcnt_q, mcnt_d;
    logic [HYST_W-1:0] miss_q, miss_d;
    logic              word_q;

    logic              match;
    logic              at_exp;
    logic              word_end;
    logic              realign;
    logic              frame_end;
    logic [POS_W-1:0]  frame_len;
    logic [N_STR-1:0]  str_trig;
    logic [N_STR-1:0]  str_pulse;

    assign frame_len = POS_W'(cfg_frame_words) * POS_W'(cfg_word_len);

    pcm_fs_corr #(
        .SYNC_MAX (SYNC_MAX),
        .TOL_W    (TOL_W)
    ) u_corr (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .pattern  (cfg_sync_pattern),
        .sync_len (cfg_sync_len),
        .tol      (cfg_tolerance),
        .match    (match)
    );

    assign realign = bit_en && (state_q == FS_SEARCH) && match;

    pcm_fs_timing #(
        .WLEN_W (WLEN_W),
        .POS_W  (POS_W)
    ) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .realign   (realign),
        .frame_len (frame_len),
        .word_len  (cfg_word_len),
        .at_exp    (at_exp),
        .word_end  (word_end)
    );

    // Next-state and hysteresis counters
    always_comb begin
        state_d = state_q;
        mcnt_d  = mcnt_q;
        miss_d  = miss_q;
        if (bit_en) begin
            unique case (state_q)
                FS_SEARCH: begin
                    if (match) begin
                        mcnt_d  = HYST_W'(1);
                        miss_d  = '0;
                        state_d = (cfg_lock_count <= HYST_W'(1)) ? FS_LOCK : FS_CHECK;
                    end
                end
                FS_CHECK: begin
                    if (at_exp) begin
                        if (match) begin
                            if ((HW1'(mcnt_q) + HW1'(1)) >= HW1'(cfg_lock_count)) begin
                                state_d = FS_LOCK;
                                miss_d  = '0;
                            end else begin
                                mcnt_d = mcnt_q + HYST_W'(1);
                            end
                        end else begin
                            state_d = FS_SEARCH;
                            mcnt_d  = '0;
                        end
                    end
                end
                FS_LOCK: begin
                    if (at_exp) begin
                        if (match) begin
                            miss_d = '0;
                        end else if ((HW1'(miss_q) + HW1'(1)) >= HW1'(cfg_loss_count)) begin
                            state_d = FS_SEARCH;
                            miss_d  = '0;
                            mcnt_d  = '0;
                        end else begin
                            miss_d = miss_q + HYST_W'(1);
                        end
                    end
                end
                default: state_d = FS_SEARCH;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_SEARCH;
            mcnt_q  <= '0;
            miss_q  <= '0;
        end else begin
            state_q <= state_d;
            mcnt_q  <= mcnt_d;
            miss_q  <= miss_d;
        end
    end

    // Output triggers
    assign frame_end        = (state_q == FS_SEARCH) ? match : at_exp;
    assign str_trig[IX_FRM] = bit_en && (state_d == FS_LOCK) && frame_end;
    assign str_trig[IX_SYN] = bit_en && frame_end && match;

    for (genvar g = 0; g < N_STR; g++) begin : g_str
        pcm_fs_stretch #(
            .STR_W (STR_W)
        ) u_str (
            .clk    (clk),
            .rst_n  (rst_n),
            .bit_en (bit_en),
            .trig   (str_trig[g]),
            .len    (cfg_stretch),
            .pulse  (str_pulse[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= 1'b0;
        end else if (bit_en) begin
            word_q <= (state_d == FS_LOCK) && word_end;
        end
    end

    assign locked      = (state_q == FS_LOCK);
    assign frame_pulse = str_pulse[IX_FRM];
    assign sync_found  = str_pulse[IX_SYN];
    assign word_pulse  = word_q;

    always_comb begin
        unique case (pulse_sel_e'(cfg_pulse_sel))
            SEL_FRAME: sel_pulse = frame_pulse;
            SEL_SYNC:  sel_pulse = sync_found;
            SEL_WORD:  sel_pulse = word_pulse;
            SEL_PPS:   sel_pulse = pps_in;
            default:   sel_pulse = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcm_frame_sync_chk.sv
module pcm_frame_sync_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       locked,
    input logic       sync_found,
    input logic       frame_pulse,
    input logic       word_pulse,
    input logic [1:0] state
);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(locked) && $stable(sync_found)
                     && $stable(frame_pulse) && $stable(word_pulse)));

    p_word_in_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_pulse |-> locked);

    p_lock_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (frame_pulse && sync_found));

    p_frame_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_pulse) |=> frame_pulse);

    p_drop_on_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(bit_en));

    p_state_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'd3);
endmodule

bind pcm_frame_sync pcm_frame_sync_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .locked      (locked),
    .sync_found  (sync_found),
    .frame_pulse (frame_pulse),
    .word_pulse  (word_pulse),
    .state       (state_q)
);

// File: tb/pcm_frame_sync_tb_top.sv
`timescale 1ns/1ps
module pcm_frame_sync_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic        pps_in = 1'b0;
    logic [63:0] pat = '0;
    int          slen = 24, tol = 0, wlen = 8, words = 8;
    int          nlock = 3, nloss = 2, str = 6;
    logic [1:0]  psel = 2'd0;
    int          gap = 0;

    logic locked, sync_found, frame_pulse, word_pulse, sel_pulse;

    pcm_frame_sync dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .bit_en           (bit_en),
        .bit_in           (bit_in),
        .pps_in           (pps_in),
        .cfg_sync_pattern (pat),
        .cfg_sync_len     (7'(slen)),
        .cfg_tolerance    (6'(tol)),
        .cfg_word_len     (5'(wlen)),
        .cfg_frame_words  (10'(words)),
        .cfg_lock_count   (5'(nlock)),
        .cfg_loss_count   (5'(nloss)),
        .cfg_stretch      (5'(str)),
        .cfg_pulse_sel    (psel),
        .locked           (locked),
        .sync_found       (sync_found),
        .frame_pulse      (frame_pulse),
        .word_pulse       (word_pulse),
        .sel_pulse        (sel_pulse)
    );

    int total = 0, bad = 0;
    bit done = 1'b0;

    task automatic check_eq(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model (0 search, 1 check, 2 lock)
    bit hist[$];
    int m_st, m_mc, m_ms, m_pos, m_wb, m_fc, m_sc;
    bit m_word;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < 64; i++) hist.push_back(1'b0);
            m_st = 0; m_mc = 0; m_ms = 0; m_pos = 0; m_wb = 0;
            m_fc = 0; m_sc = 0; m_word = 0;
        end else if (bit_en) begin
            int errs, flen, pinc, winc, nst;
            bit good, expct, fe, ra;
            hist.push_back(bit_in);
            void'(hist.pop_front());
            errs = 0;
            for (int i = 0; i < slen; i++)
                if (hist[63 - i] != pat[i]) errs++;
            good  = (errs <= tol);
            flen  = words * wlen;
            pinc  = (m_pos >= flen - 1) ? 0 : m_pos + 1;
            winc  = (m_wb >= wlen - 1) ? 0 : m_wb + 1;
            expct = (pinc == flen - 1);
            fe    = (m_st == 0) ? good : expct;
            nst   = m_st;
            if (m_st == 0) begin
                if (good) begin m_mc = 1; m_ms = 0; nst = (nlock == 1) ? 2 : 1; end
            end else if (m_st == 1) begin
                if (expct) begin
                    if (!good) begin nst = 0; m_mc = 0; end
                    else if (m_mc + 1 >= nlock) begin nst = 2; m_ms = 0; end
                    else m_mc++;
                end
            end else begin
                if (expct) begin
                    if (good) m_ms = 0;
                    else if (m_ms + 1 >= nloss) begin nst = 0; m_ms = 0; m_mc = 0; end
                    else m_ms++;
                end
            end
            ra     = (m_st == 0) && good;
            m_pos  = ra ? flen - 1 : pinc;
            m_wb   = ra ? wlen - 1 : winc;
            m_word = (nst == 2) && (m_wb == wlen - 1);
            if (nst == 2 && fe) m_fc = str; else if (m_fc > 0) m_fc--;
            if (fe && good) m_sc = str; else if (m_sc > 0) m_sc--;
            m_st = nst;
        end
    end

    // Compare with the model every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_sel;
            case (psel)
                2'd0: exp_sel = (m_fc > 0);
                2'd1: exp_sel = (m_sc > 0);
                2'd2: exp_sel = m_word;
                default: exp_sel = pps_in;
            endcase
            check_eq("R3/R4 locked vs model", int'(locked), int'(m_st == 2));
            check_eq("R5 frame_pulse vs model", int'(frame_pulse), int'(m_fc > 0));
            check_eq("R6 sync_found vs model", int'(sync_found), int'(m_sc > 0));
            check_eq("R7 word_pulse vs model", int'(word_pulse), int'(m_word));
            check_eq("R8 sel_pulse vs model", int'(sel_pulse), int'(exp_sel));
        end
    end

    // Stimulus helpers
    logic [15:0] lfsr = 16'hACE1;
    int fcnt, scnt, wcnt;

    task automatic drive_bit(input logic b);
        for (int g = 0; g < gap; g++) begin
            bit_en = 1'b0;
            @(posedge clk); #1;
        end
        bit_en = 1'b1;
        bit_in = b;
        @(posedge clk); #1;
        bit_en = 1'b0;
        if (frame_pulse) fcnt++;
        if (sync_found) scnt++;
        if (word_pulse) wcnt++;
    endtask

    task automatic send_data(input int n);
        fcnt = 0; scnt = 0; wcnt = 0;
        for (int k = 0; k < n; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive_bit(lfsr[0]);
        end
    endtask

    // Oldest pattern bit first; flips the nflip lowest pattern bits
    task automatic send_sync(input int nflip);
        for (int i = slen - 1; i >= 0; i--) drive_bit(pat[i] ^ (i < nflip));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        pat = 64'hC3A5_5A3C_00FA_F320;   // upper bits above length 24 set (R11)
        @(posedge clk); #1;
        do_reset();
        @(posedge clk); #1;
        check_eq("R10 locked after reset", int'(locked), 0);
        check_eq("R10 sync_found after reset", int'(sync_found), 0);
        check_eq("R10 frame_pulse after reset", int'(frame_pulse), 0);
        check_eq("R10 word_pulse after reset", int'(word_pulse), 0);

        // Config A: F = 64 bits, lock after 3, loss after 2, stretch 6
        send_data(30);
        send_sync(0); check_eq("R3 no lock after 1st sync", int'(locked), 0);
        check_eq("R11 R6 sync found with masked upper bits", int'(sync_found), 1);
        send_data(40);
        send_sync(0); check_eq("R3 no lock after 2nd sync", int'(locked), 0);
        send_data(40);
        send_sync(0); check_eq("R3 lock on 3rd sync", int'(locked), 1);
        check_eq("R6 sync_found on lock bit", int'(sync_found), 1);
        send_data(40);
        check_eq("R5 frame_pulse extra bit times", fcnt, 5);
        check_eq("R6 sync_found extra bit times", scnt, 5);
        check_eq("R7 word pulses in data", wcnt, 5);

        // Tolerance edge
        tol = 2; psel = 2'd1;
        send_sync(2); check_eq("R1 two errors within tolerance", int'(sync_found), 1);
        send_data(40);
        // Off-position sync while locked
        send_data(30);
        send_sync(0); check_eq("R2 off-position sync ignored", int'(sync_found), 0);
        send_data(10); check_eq("R4 one miss keeps lock", int'(locked), 1);
        send_sync(0); check_eq("R2 on-position sync accepted", int'(sync_found), 1);
        send_data(40);
        send_sync(3); check_eq("R1 three errors rejected", int'(sync_found), 0);
        check_eq("R4 lock held after one miss", int'(locked), 1);
        send_data(40);
        send_sync(0); send_data(40);
        send_sync(3); check_eq("R4 miss count restarted", int'(locked), 1);
        send_data(40);
        send_sync(3); check_eq("R4 loss on 2nd consecutive miss", int'(locked), 0);

        // Reacquire with bit_en gaps; a failed check returns to search
        psel = 2'd2; gap = 2;
        send_data(40);
        send_sync(0); check_eq("R3 search match alone no lock", int'(locked), 0);
        send_data(40);
        send_sync(3); check_eq("R3 failed check no lock", int'(locked), 0);
        send_data(40);
        send_sync(0); send_data(40);
        send_sync(0); check_eq("R3 count restarted after reject", int'(locked), 0);
        send_data(40);
        send_sync(0); check_eq("R3 relock after 3 fresh matches", int'(locked), 1);

        // No change while bit_en is low
        bit_en = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        check_eq("R9 frame_pulse held without bit_en", int'(frame_pulse), 1);
        check_eq("R9 locked held without bit_en", int'(locked), 1);
        send_data(40);
        check_eq("R5 stretch in bit times with gaps", fcnt, 5);

        // Selector passes the external second pulse
        psel = 2'd3; pps_in = 1'b1;
        @(posedge clk); #1;
        check_eq("R8 sel follows pps high", int'(sel_pulse), 1);
        pps_in = 1'b0;
        @(posedge clk); #1;
        check_eq("R8 sel follows pps low", int'(sel_pulse), 0);

        // Config B: 16-bit words, 6 words, lock 1, loss 1, stretch 16
        gap = 0; psel = 2'd0;
        pat = 64'h1234_5678_FE6B_2840;
        slen = 32; tol = 1; wlen = 16; words = 6;
        nlock = 1; nloss = 1; str = 16;
        do_reset();
        send_data(20);
        send_sync(1); check_eq("R3 lock count 1 locks at once", int'(locked), 1);
        send_data(64);
        check_eq("R5 frame_pulse stretch 16", fcnt, 15);
        check_eq("R7 word pulses with 16-bit words", wcnt, 4);
        send_sync(0); check_eq("R4 good sync keeps lock", int'(locked), 1);
        send_data(64);
        send_sync(2); check_eq("R4 loss count 1 drops at once", int'(locked), 0);
        send_data(10);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule